// File: doc/BRIEF.md
# Linear CCD Line Clock Sequencer

This block derives every logic-level clock that a two-output linear CCD line sensor needs from one fast system clock. Each pixel period lasts `DIV` system clocks. In each period the block produces a pair of complementary readout phases, a last-gate clock that follows the first phase, and a short output reset pulse placed inside the first half of the period. One pixel period at the start of each line carries the charge transfer pulse. An optional exposure pulse clears the storage wells part way through the line, which shortens the integration time.

The line is a sequence of pixel periods. It opens with a lead-in of `LEAD_PIX` periods, of which the transfer period is the first. Next come the active pixels of one tap, which number half the sensor length. Then come the dark pixels (isolation plus shielded) and a programmable number of overclock periods. The next line follows at once. Two strobes go to the video capture logic. The line-start strobe marks the transfer period. The pixel-valid strobe fires once per active pixel at the middle of the period. The sensor length, overclock count and exposure settings are taken at synchronous reset and at each line end. A change made in the middle of a line therefore applies only from the next line.

Top module: `ccd_linegen`

## Requirements
- R1: Within every pixel period of `DIV` system clocks, `cr1` is high for the first `DIV/2` clocks and low for the rest. `cr2` is always its complement.
- R2: `crlast` is equal to `cr1` in every cycle.
- R3: `tck` is high only during pixel 0 of a line, at phases 0 to `DIV/2-2`. It is therefore high only while `cr1` is high, and it falls at least one clock before `cr1` falls.
- R4: `ccd_rst` is high at phases 1 to `DIV/2-2` of every pixel period. It rises after `crlast` rises and falls before `crlast` falls.
- R5: A line lasts `LEAD_PIX + ISO_PIX + SHLD_PIX + A + oc_count` pixel periods, where A is 256, 512 or 1024 for `sens_code` 0, 1 or 2. Code 3 is treated as code 2. `line_start` is high for exactly one clock, at phase 0 of pixel 0.
- R6: `pix_valid` is high for one clock at phase `DIV/2` of pixels `LEAD_PIX` through `LEAD_PIX+A-1`, and at no other time.
- R7: With exposure enabled, `pr` is high during pixels 1 to D of the line, where D is `exp_dly`. If D is 0 there is no pulse. `pr` is never high together with `tck`. The integration time, from the fall of `pr` to the next rise of `tck`, is `(L-1-D)*DIV` clocks for a line of L periods.
- R8: D is clamped to L-2, so `pr` falls at least one full pixel period before the next `tck`.
- R9: The settings `sens_code`, `oc_count`, `exp_en` and `exp_dly` are sampled only during synchronous reset and at the last clock of a line. Changes at any other time leave the current line unchanged.
- R10: While `rst` is high, and on the first clock after it, the outputs hold the idle state: `cr1` and `crlast` high, and `cr2`, `tck`, `pr`, `ccd_rst`, `pix_valid` and `line_start` low.
- R11: With exposure disabled, `pr` stays low for the whole line, whatever `exp_dly` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sens_code | input | 2 | Sensor length: 0 = 512, 1 = 1024, 2 or 3 = 2048 |
| oc_count | input | OCW | Overclock periods appended to each line |
| exp_en | input | 1 | Enables the exposure pulse |
| exp_dly | input | PXW | Last pixel period in which the exposure pulse is high |
| cr1 | output | 1 | Readout phase 1 |
| cr2 | output | 1 | Readout phase 2, complement of phase 1 |
| crlast | output | 1 | Last-gate clock, in phase with phase 1 |
| ccd_rst | output | 1 | Output node reset pulse |
| tck | output | 1 | Charge transfer pulse |
| pr | output | 1 | Exposure (pixel reset) pulse |
| pix_valid | output | 1 | One-clock strobe per active pixel |
| line_start | output | 1 | One-clock strobe at line start |

## Verification
Every output is compared cycle by cycle against a model of the line and pixel sequence. The stimulus is a run of random lines mixed with directed corner lines. The random lines vary the sensor code, the overclock count and the exposure delay, and their settings change in the middle of a line. A mismatch in the line length or in the active window separates errors in the count of one part of the line from errors in the total. Setting a new configuration mid-line shows whether the design samples its settings too early. The directed lines cover a zero delay, a delay far beyond the line (clamp), exposure disabled, code 3, and zero and maximum overclock. The measured integration time and line period check the exposure and length arithmetic end to end.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

   // sensor length selector; code 3 falls back to the longest sensor
   typedef enum logic [1:0] {
      SENS_512   = 2'd0,
      SENS_1024  = 2'd1,
      SENS_2048  = 2'd2,
      SENS_2048B = 2'd3
   } sens_len_e;

   localparam int unsigned MAX_TAP_ACTIVE = 1024;

   // active pixels carried by one output tap
   function automatic int unsigned tap_active(input logic [1:0] code);
      case (sens_len_e'(code))
         SENS_512:  return 256;
         SENS_1024: return 512;
         default:   return MAX_TAP_ACTIVE;
      endcase
   endfunction

   // bundle of registered clock outputs
   typedef struct packed {
      logic cr1;
      logic cr2;
      logic crlast;
      logic rst;
      logic tck;
      logic pr;
      logic pvalid;
      logic lstart;
   } ccd_wave_t;

   localparam ccd_wave_t WAVE_IDLE = '{cr1: 1'b1, cr2: 1'b0, crlast: 1'b1,
                                       rst: 1'b0, tck: 1'b0, pr: 1'b0,
                                       pvalid: 1'b0, lstart: 1'b0};

endpackage

// File: rtl/ccdtg_pix_timer.sv
module ccdtg_pix_timer #(
   parameter int DIV = 8,
   localparam int PHW = $clog2(DIV)
) (
   input  logic           clk,
   input  logic           rst,
   output logic [PHW-1:0] ph,
   output logic           ph_last
);

   localparam logic [PHW-1:0] PH_END = PHW'(DIV - 1);

   assign ph_last = (ph == PH_END);

   generate
      if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         // divider is a power of two: natural wrap of the counter
         always_ff @(posedge clk) begin
            if (rst) ph <= '0;
            else     ph <= ph + PHW'(1);
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (rst)          ph <= '0;
            else if (ph_last) ph <= '0;
            else              ph <= ph + PHW'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/ccdtg_line_ctr.sv
module ccdtg_line_ctr
   import ccdtg_pkg::*;
#(
   parameter int LEAD_PIX = 23,
   parameter int ISO_PIX  = 10,
   parameter int SHLD_PIX = 16,
   parameter int OCW      = 8,
   parameter int PXW      = 11
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           ph_last,
   input  logic [1:0]     sens_code,
   input  logic [OCW-1:0] oc_count,
   input  logic           exp_en,
   input  logic [PXW-1:0] exp_dly,
   output logic [PXW-1:0] px,
   output logic [PXW-1:0] act_cnt,
   output logic [PXW-1:0] pr_end,
   output logic           pr_on
);

   localparam int FIXED_PIX = LEAD_PIX + ISO_PIX + SHLD_PIX;

   logic [1:0]     code_q;
   logic [OCW-1:0] oc_q;
   logic           en_q;
   logic [PXW-1:0] dly_q;
   logic [PXW-1:0] len_m1;
   logic [PXW-1:0] dly_lim;
   logic           wrap;

   assign act_cnt = PXW'(tap_active(code_q));
   assign len_m1  = PXW'(FIXED_PIX) + act_cnt + PXW'(oc_q) - PXW'(1);
   assign dly_lim = len_m1 - PXW'(1);
   assign pr_end  = (dly_q > dly_lim) ? dly_lim : dly_q;
   assign pr_on   = en_q;
   assign wrap    = ph_last && (px == len_m1);

   // settings are taken only in reset and on the last clock of a line
   always_ff @(posedge clk) begin
      if (rst || wrap) begin
         code_q <= sens_code;
         oc_q   <= oc_count;
         en_q   <= exp_en;
         dly_q  <= exp_dly;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || wrap) px <= '0;
      else if (ph_last) px <= px + PXW'(1);
   end

endmodule

// File: rtl/ccdtg_wave_gen.sv
module ccdtg_wave_gen
   import ccdtg_pkg::*;
#(
   parameter int DIV      = 8,
   parameter int LEAD_PIX = 23,
   parameter int PXW      = 11,
   localparam int PHW     = $clog2(DIV)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [PHW-1:0] ph,
   input  logic [PXW-1:0] px,
   input  logic [PXW-1:0] act_cnt,
   input  logic [PXW-1:0] pr_end,
   input  logic           pr_on,
   output ccd_wave_t      wave
);

   localparam int HALF = DIV / 2;
   localparam logic [PHW-1:0] PH_HALF   = PHW'(HALF);
   localparam logic [PHW-1:0] PH_ONE    = PHW'(1);
   localparam logic [PHW-1:0] PH_NARROW = PHW'(HALF - 2);
   localparam logic [PXW-1:0] PX_LEAD   = PXW'(LEAD_PIX);

   logic      first_half;
   logic      px_zero;
   logic      in_active;
   ccd_wave_t nxt;

   assign first_half = (ph < PH_HALF);
   assign px_zero    = (px == '0);
   assign in_active  = (px >= PX_LEAD) && (px < PX_LEAD + act_cnt);

   always_comb begin
      nxt.cr1    = first_half;
      nxt.cr2    = ~first_half;
      nxt.crlast = first_half;
      nxt.rst    = (ph >= PH_ONE) && (ph <= PH_NARROW);
      nxt.tck    = px_zero && (ph <= PH_NARROW);
      nxt.pr     = pr_on && !px_zero && (px <= pr_end);
      nxt.pvalid = in_active && (ph == PH_HALF);
      nxt.lstart = px_zero && (ph == '0);
   end

   always_ff @(posedge clk) begin
      if (rst) wave <= WAVE_IDLE;
      else     wave <= nxt;
   end

endmodule

// File: rtl/ccd_linegen.sv
module ccd_linegen
   import ccdtg_pkg::*;
#(
   parameter int DIV      = 8,
   parameter int LEAD_PIX = 23,
   parameter int ISO_PIX  = 10,
   parameter int SHLD_PIX = 16,
   parameter int OCW      = 8,
   localparam int PXW     = $clog2(LEAD_PIX + ISO_PIX + SHLD_PIX + MAX_TAP_ACTIVE + (1 << OCW)),
   localparam int PHW     = $clog2(DIV)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [1:0]     sens_code,
   input  logic [OCW-1:0] oc_count,
   input  logic           exp_en,
   input  logic [PXW-1:0] exp_dly,
   output logic           cr1,
   output logic           cr2,
   output logic           crlast,
   output logic           ccd_rst,
   output logic           tck,
   output logic           pr,
   output logic           pix_valid,
   output logic           line_start
);

   generate
      if ((DIV % 2) != 0 || DIV < 6) begin : g_bad_div
         $error("ccd_linegen: DIV must be even and at least 6");
      end
      if (OCW < 1 || OCW > 12) begin : g_bad_ocw
         $error("ccd_linegen: OCW out of range 1..12");
      end
      if (LEAD_PIX < 1) begin : g_bad_lead
         $error("ccd_linegen: LEAD_PIX must be at least 1");
      end
   endgenerate

   logic [PHW-1:0] ph;
   logic           ph_last;
   logic [PXW-1:0] px;
   logic [PXW-1:0] act_cnt;
   logic [PXW-1:0] pr_end;
   logic           pr_on;
   ccd_wave_t      wave;

   ccdtg_pix_timer #(.DIV(DIV)) u_pix (
      .clk     (clk),
      .rst     (rst),
      .ph      (ph),
      .ph_last (ph_last)
   );

   ccdtg_line_ctr #(
      .LEAD_PIX (LEAD_PIX),
      .ISO_PIX  (ISO_PIX),
      .SHLD_PIX (SHLD_PIX),
      .OCW      (OCW),
      .PXW      (PXW)
   ) u_line (
      .clk       (clk),
      .rst       (rst),
      .ph_last   (ph_last),
      .sens_code (sens_code),
      .oc_count  (oc_count),
      .exp_en    (exp_en),
      .exp_dly   (exp_dly),
      .px        (px),
      .act_cnt   (act_cnt),
      .pr_end    (pr_end),
      .pr_on     (pr_on)
   );

   ccdtg_wave_gen #(
      .DIV      (DIV),
      .LEAD_PIX (LEAD_PIX),
      .PXW      (PXW)
   ) u_wave (
      .clk     (clk),
      .rst     (rst),
      .ph      (ph),
      .px      (px),
      .act_cnt (act_cnt),
      .pr_end  (pr_end),
      .pr_on   (pr_on),
      .wave    (wave)
   );

   assign cr1        = wave.cr1;
   assign cr2        = wave.cr2;
   assign crlast     = wave.crlast;
   assign ccd_rst    = wave.rst;
   assign tck        = wave.tck;
   assign pr         = wave.pr;
   assign pix_valid  = wave.pvalid;
   assign line_start = wave.lstart;

endmodule

// File: rtl/ccdtg_chk.sv
module ccdtg_chk #(
   parameter int DIV = 8
) (
   input logic clk,
   input logic rst,
   input logic cr1,
   input logic cr2,
   input logic crlast,
   input logic ccd_rst,
   input logic tck,
   input logic pr,
   input logic pix_valid,
   input logic line_start
);

   localparam int CW = $clog2(DIV + 1);

   logic          rst_d = 1'b0;
   logic [CW-1:0] pr_low_cnt;

   always_ff @(posedge clk) rst_d <= rst;

   // consecutive clocks with pr low, saturating at DIV
   always_ff @(posedge clk) begin
      if (rst)                          pr_low_cnt <= CW'(DIV);
      else if (pr)                      pr_low_cnt <= '0;
      else if (pr_low_cnt != CW'(DIV))  pr_low_cnt <= pr_low_cnt + CW'(1);
   end

   // R1
   phase_compl_chk: assert property (@(posedge clk) disable iff (rst)
      cr1 != cr2);

   // R2
   last_gate_chk: assert property (@(posedge clk) disable iff (rst)
      crlast == cr1);

   // R3
   tck_inside_chk: assert property (@(posedge clk) disable iff (rst)
      tck |-> cr1);

   // R3
   tck_early_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(cr1) |-> !$past(tck));

   // R4
   rst_inside_chk: assert property (@(posedge clk) disable iff (rst)
      ccd_rst |-> crlast);

   // R4
   rst_early_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(crlast) |-> !$past(ccd_rst));

   // R4
   rst_late_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(crlast) |-> !ccd_rst);

   // R5
   line_at_tck_chk: assert property (@(posedge clk) disable iff (rst)
      line_start |-> tck);

   // R6
   valid_second_half_chk: assert property (@(posedge clk) disable iff (rst)
      pix_valid |-> (!cr1 && !tck));

   // R7
   pr_tck_excl_chk: assert property (@(posedge clk) disable iff (rst)
      tck |-> !pr);

   // R8
   pr_margin_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(tck) |-> (pr_low_cnt >= CW'(DIV)));

   // R10
   reset_idle_chk: assert property (@(posedge clk)
      rst_d |-> (cr1 && crlast && !cr2 && !tck && !pr && !ccd_rst && !pix_valid && !line_start));

endmodule

bind ccd_linegen ccdtg_chk #(.DIV(DIV)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cr1        (cr1),
   .cr2        (cr2),
   .crlast     (crlast),
   .ccd_rst    (ccd_rst),
   .tck        (tck),
   .pr         (pr),
   .pix_valid  (pix_valid),
   .line_start (line_start)
);

// File: tb/ccd_linegen_test.sv
module ccd_linegen_test;

   localparam int DIV      = 8;
   localparam int LEAD_PIX = 23;
   localparam int ISO_PIX  = 10;
   localparam int SHLD_PIX = 16;
   localparam int OCW      = 8;
   localparam int PXW      = $clog2(LEAD_PIX + ISO_PIX + SHLD_PIX + 1024 + (1 << OCW));
   localparam int HALF     = DIV / 2;

   logic           clk = 1'b0;
   logic           rst;
   logic [1:0]     sens_code;
   logic [OCW-1:0] oc_count;
   logic           exp_en;
   logic [PXW-1:0] exp_dly;
   logic cr1, cr2, crlast, ccd_rst, tck, pr, pix_valid, line_start;

   always #5 clk = ~clk;

   ccd_linegen #(
      .DIV(DIV), .LEAD_PIX(LEAD_PIX), .ISO_PIX(ISO_PIX),
      .SHLD_PIX(SHLD_PIX), .OCW(OCW)
   ) uut (
      .clk(clk), .rst(rst), .sens_code(sens_code), .oc_count(oc_count),
      .exp_en(exp_en), .exp_dly(exp_dly), .cr1(cr1), .cr2(cr2),
      .crlast(crlast), .ccd_rst(ccd_rst), .tck(tck), .pr(pr),
      .pix_valid(pix_valid), .line_start(line_start)
   );

   int  n_cmp  = 0;
   int  n_bad  = 0;
   bit  done   = 1'b0;
   bit  run_on = 1'b0;

   function automatic int act_of(input logic [1:0] c);
      return (c == 2'd0) ? 256 : (c == 2'd1) ? 512 : 1024;
   endfunction

   function automatic int len_of(input logic [1:0] c, input int oc);
      return LEAD_PIX + ISO_PIX + SHLD_PIX + act_of(c) + oc;
   endfunction

   function automatic int clamp_of(input int d, input int len);
      return (d > len - 2) ? len - 2 : d;
   endfunction

   // expected bits: cr1 cr2 crlast rst tck pr valid lstart
   function automatic logic [7:0] expect_of(input int ph, input int px,
                                            input logic [1:0] c, input int oc,
                                            input bit en, input int d);
      logic [7:0] v;
      int dc;
      dc   = clamp_of(d, len_of(c, oc));
      v[7] = (ph < HALF);
      v[6] = !(ph < HALF);
      v[5] = (ph < HALF);
      v[4] = (ph >= 1) && (ph <= HALF - 2);
      v[3] = (px == 0) && (ph <= HALF - 2);
      v[2] = en && (px >= 1) && (px <= dc);
      v[1] = (ph == HALF) && (px >= LEAD_PIX) && (px < LEAD_PIX + act_of(c));
      v[0] = (px == 0) && (ph == 0);
      return v;
   endfunction

   // reference model state
   int         m_ph, m_px, m_oc, m_dly, m_lines;
   logic [1:0] m_code;
   bit         m_en;
   logic [7:0] exp_v = 8'b1010_0000;

   always @(posedge clk) begin
      if (rst) begin
         m_ph = 0; m_px = 0;
         m_code = sens_code; m_oc = int'(oc_count); m_en = exp_en; m_dly = int'(exp_dly);
         exp_v = 8'b1010_0000;
      end else begin
         exp_v = expect_of(m_ph, m_px, m_code, m_oc, m_en, m_dly);
         if (m_ph == DIV - 1) begin
            m_ph = 0;
            if (m_px == len_of(m_code, m_oc) - 1) begin
               m_px = 0;
               m_code = sens_code; m_oc = int'(oc_count); m_en = exp_en; m_dly = int'(exp_dly);
               m_lines++;
            end else m_px++;
         end else m_ph++;
      end
   end

   task automatic check(input string req, input int act, input int expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // per-cycle comparison and end-to-end measurements, sampled at negedge
   int   cyc = 0;
   int   pr_fall_cyc = -1, pr_int_exp = 0;
   int   ls_cyc = -1, ls_len_exp = 0;
   logic pr_q = 1'b0, tck_q = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (run_on) begin
         check("R1 cr1",        int'(cr1),        int'(exp_v[7]));
         check("R1 cr2",        int'(cr2),        int'(exp_v[6]));
         check("R2 crlast",     int'(crlast),     int'(exp_v[5]));
         check("R4 ccd_rst",    int'(ccd_rst),    int'(exp_v[4]));
         check("R3 tck",        int'(tck),        int'(exp_v[3]));
         check("R7 R11 pr",     int'(pr),         int'(exp_v[2]));
         check("R6 pix_valid",  int'(pix_valid),  int'(exp_v[1]));
         check("R5 line_start", int'(line_start), int'(exp_v[0]));
         // R7 R8: integration time from pr fall to tck rise
         if (pr_q && !pr) begin
            pr_fall_cyc = cyc;
            pr_int_exp  = (len_of(m_code, m_oc) - 1 - clamp_of(m_dly, len_of(m_code, m_oc))) * DIV;
         end
         if (!tck_q && tck && pr_fall_cyc >= 0) begin
            check("R8 integration", cyc - pr_fall_cyc, pr_int_exp);
            pr_fall_cyc = -1;
         end
         // R5: line period between successive line_start strobes
         if (line_start) begin
            if (ls_cyc >= 0) check("R5 line period", cyc - ls_cyc, ls_len_exp);
            ls_cyc     = cyc;
            ls_len_exp = len_of(m_code, m_oc) * DIV;
         end
         if (n_bad > 40) summary();
      end
      pr_q  = pr;
      tck_q = tck;
   end

   // watchdog
   initial begin
      repeat (160000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end

   task automatic drive(input logic [1:0] c, input int oc, input bit en, input int d);
      sens_code = c;
      oc_count  = OCW'(oc);
      exp_en    = en;
      exp_dly   = PXW'(d);
   endtask

   // R9: settings are changed mid-line; the model latches them only at line end
   task automatic next_line(input logic [1:0] c, input int oc, input bit en, input int d);
      int start;
      start = m_lines;
      repeat (40 + ($urandom % 300)) @(negedge clk);
      drive(c, oc, en, d);
      while (m_lines == start) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1;
      drive(2'd0, 3, 1'b1, 40);
      repeat (3) @(negedge clk);
      // R10: idle state while in reset
      check("R10 reset cr1",    int'(cr1),    1);
      check("R10 reset crlast", int'(crlast), 1);
      check("R10 reset others", int'({cr2, tck, pr, ccd_rst, pix_valid, line_start}), 0);
      rst = 1'b0;
      run_on = 1'b1;
      @(negedge clk);
      // R10: first cycle after reset shows pixel 0 phase 0
      check("R10 first tck", int'(tck), 1);

      next_line(2'd0, 0, 1'b1, 0);       // R7 zero delay: no pulse
      next_line(2'd0, 7, 1'b1, 2047);    // R8 clamp
      next_line(2'd1, 255, 1'b0, 300);   // R11 exposure off, max overclock
      next_line(2'd3, 0, 1'b1, 900);     // R5 code 3 as 2048
      next_line(2'd0, 12, 1'b1, 1);      // R7 single-pixel pulse
      for (int i = 0; i < 8; i++) begin
         next_line(2'($urandom % 2), int'($urandom % 256), 1'($urandom % 4 != 0),
                   int'($urandom % 700));
      end
      next_line(2'd2, 50, 1'b1, 600);
      next_line(2'd0, 0, 1'b1, 100);
      repeat (20) @(negedge clk);
      summary();
   end

endmodule